// File: doc/BRIEF.md
# PCM Frame and Bit-Phase Aligner

This block is the timing front end of a 2048 kbit/s serial PCM highway. It runs from a clock at four times the data rate, so every serial bit spans four clock periods, called phases 0 to 3. A frame sync pulse fixes where each 256-bit frame begins. Two lanes pass through the block: a receive lane and a send lane. Each lane samples its serial input once per bit and launches its serial output once per bit. A full frame of data is held between input and output.

Every rising edge of `clk` is an active edge. Inputs are sampled on these edges and outputs change on them. The sync can be taken on the active edge itself. It can also be captured half a period earlier, on the falling edge of `clk`, and then acted on at the next active edge. The sync polarity is selectable. The bit phase that is loaded when a sync is first seen is configurable, which allows alignment finer than one bit. Per-stream frame offsets shift the frame start of the receive input, the send input and the send output independently. A bypass setting routes each input straight to its output path.

A lock flag reports that syncs keep arriving exactly one frame apart. All configuration inputs are static settings and are changed only while reset is held.

Top module: `pcm_phase_aligner`

## Requirements
- R1: Position in the frame is a phase count (0..3) and a bit count (0..255). Between syncs the phase advances by one on every active edge. The bit count advances when the phase wraps from 3 to 0, and it wraps from 255 to 0.
- R2: Each lane's serial input is captured only on the active edge where the phase becomes 2. The input level during the other phases of the bit has no effect on the output.
- R3: Each lane's serial output changes only on the active edge where the phase becomes 0. It then holds its value for all four phases of the bit.
- R4: `cfg_sync_high` = 0 makes a low level on `frm_sync` the active sync level. `cfg_sync_high` = 1 makes a high level the active level.
- R5: With `cfg_sync_early` = 0, `frm_sync` is sampled on the active edge, and a pulse that is absent at that edge is ignored. With `cfg_sync_early` = 1, `frm_sync` is captured on the falling edge of `clk`, and the next active edge becomes the synchronization point.
- R6: At the synchronization point of the first active sample after an inactive one, the phase is loaded with `cfg_phase` and the bit count with 0. A sync held active for longer counts only once.
- R7: Without bypass, the send output at a given bit equals the send input from D bits earlier. D = (`cfg_tx_out_ofs` − `cfg_tx_in_ofs`) mod 256, and a value of 0 means 256. The receive output follows the same rule with an output offset of 0 and `cfg_rx_in_ofs` as the input offset. With all offsets at zero, D is exactly one frame (256 bits).
- R8: With `cfg_bypass` = 1, each output at a given bit carries its input sampled in the bit just before.
- R9: `locked` rises on the second consecutive sync that arrives where the free-running count expected one. The expected place is where the next state would be phase `cfg_phase` with bit count 0.
- R10: `locked` falls, and the streak restarts, when a sync arrives at an unexpected position or when the expected position passes without a sync.
- R11: During and right after reset, `rx_dout`, `tx_dout` and `locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bit rate; rising edge is the active edge |
| rst | input | 1 | Synchronous active-high reset |
| frm_sync | input | 1 | Frame sync pulse |
| cfg_sync_high | input | 1 | 1: sync active high, 0: active low |
| cfg_sync_early | input | 1 | 1: capture sync on the falling edge of clk |
| cfg_phase | input | 2 | Phase loaded at the synchronization point |
| cfg_rx_in_ofs | input | 8 | Receive input frame offset in bits |
| cfg_tx_in_ofs | input | 8 | Send input frame offset in bits |
| cfg_tx_out_ofs | input | 8 | Send output frame offset in bits |
| cfg_bypass | input | 1 | 1: inputs go straight to the output path |
| rx_din | input | 1 | Receive serial input |
| tx_din | input | 1 | Send serial input |
| rx_dout | output | 1 | Receive serial output |
| tx_dout | output | 1 | Send serial output |
| locked | output | 1 | Frame sync lock flag |

## Verification
A sync reload can fall on the same active edge as a data capture or an output launch. This happens when `cfg_phase` is 2 or 0, because the reloaded phase then triggers the strobe on that very edge. The bench sets `cfg_phase` to 2 in one scenario and to 0 in another. In each, it drives input bits that are valid only in the phase before capture. A capture that slipped by a phase, or a missing capture on the sync edge, would show up as the wrong output bit one frame later. The bench compares every output sample against the input stream it drove itself, shifted by the delay the offsets imply.

// File: rtl/pcm_align_pkg.sv
`timescale 1ns/1ps
package pcm_align_pkg;

    localparam int PHASES       = 4;
    localparam int PH_W         = 2;
    localparam int DEF_FRAME    = 256;
    localparam int DEF_LOCK     = 2;
    localparam int LANES        = 2;
    localparam int LANE_RX      = 0;
    localparam int LANE_TX      = 1;

    localparam logic [PH_W-1:0] PH_LAUNCH = 2'd0;
    localparam logic [PH_W-1:0] PH_SAMPLE = 2'd2;
    localparam logic [PH_W-1:0] PH_LAST   = 2'(PHASES - 1);

    typedef struct packed {
        logic sample;
        logic launch;
    } strobe_t;

    typedef struct packed {
        logic reload;
        logic on_grid;
    } sync_info_t;

    function automatic int wrap_sub(int a, int b, int modulus);
        return (a >= b) ? (a - b) : (a + modulus - b);
    endfunction

endpackage

// File: rtl/pcm_sync_detect.sv
`timescale 1ns/1ps
module pcm_sync_detect (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic cfg_high,
    input  logic cfg_early,
    output logic evt
);

    logic act_now;
    logic early_cap;
    logic src;
    logic prev_q;

    assign act_now = cfg_high ? sync_in : ~sync_in;

    always_ff @(negedge clk) begin
        if (rst) begin
            early_cap <= 1'b0;
        end else begin
            early_cap <= act_now;
        end
    end

    assign src = cfg_early ? early_cap : act_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= src;
        end
    end

    assign evt = src & ~prev_q & ~rst;

endmodule

// File: rtl/pcm_frame_timer.sv
`timescale 1ns/1ps
module pcm_frame_timer
    import pcm_align_pkg::*;
#(
    parameter int FRAME_BITS = DEF_FRAME,
    parameter int LOCK_SYNCS = DEF_LOCK,
    localparam int POS_W     = $clog2(FRAME_BITS),
    localparam int STRK_W    = $clog2(LOCK_SYNCS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic [PH_W-1:0]   cfg_phase,
    output logic [POS_W-1:0]  bit_nxt,
    output strobe_t           strobe,
    output logic              locked
);

    logic [PH_W-1:0]   phase_q;
    logic [POS_W-1:0]  bit_q;
    logic [PH_W-1:0]   free_ph;
    logic [POS_W-1:0]  free_bit;
    logic [PH_W-1:0]   phase_nxt;
    logic [STRK_W-1:0] streak_q;
    sync_info_t        info;

    always_comb begin
        free_ph  = phase_q + PH_W'(1);
        free_bit = bit_q;
        if (phase_q == PH_LAST) begin
            free_bit = (bit_q == POS_W'(FRAME_BITS - 1)) ? '0 : bit_q + POS_W'(1);
        end
    end

    assign info.reload  = evt;
    assign info.on_grid = (free_ph == cfg_phase) && (free_bit == '0);

    assign phase_nxt = info.reload ? cfg_phase : free_ph;
    assign bit_nxt   = info.reload ? '0 : free_bit;

    assign strobe.sample = (phase_nxt == PH_SAMPLE);
    assign strobe.launch = (phase_nxt == PH_LAUNCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            bit_q   <= '0;
        end else begin
            phase_q <= phase_nxt;
            bit_q   <= bit_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            streak_q <= '0;
        end else if (info.reload) begin
            if (!info.on_grid) begin
                streak_q <= '0;
            end else if (streak_q != STRK_W'(LOCK_SYNCS)) begin
                streak_q <= streak_q + STRK_W'(1);
            end
        end else if (info.on_grid) begin
            streak_q <= '0;
        end
    end

    assign locked = (streak_q == STRK_W'(LOCK_SYNCS));

endmodule

// File: rtl/pcm_delay_lane.sv
`timescale 1ns/1ps
module pcm_delay_lane
    import pcm_align_pkg::*;
#(
    parameter int FRAME_BITS = DEF_FRAME,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  strobe_t          strobe,
    input  logic [POS_W-1:0] bit_nxt,
    input  logic [POS_W-1:0] in_ofs,
    input  logic [POS_W-1:0] out_ofs,
    input  logic             bypass,
    input  logic             din,
    output logic             dout
);

    logic [FRAME_BITS-1:0] store_q;
    logic [POS_W-1:0]      wr_pos;
    logic [POS_W-1:0]      rd_pos;
    logic                  last_in_q;

    assign wr_pos = POS_W'(wrap_sub(int'(bit_nxt), int'(in_ofs), FRAME_BITS));
    assign rd_pos = POS_W'(wrap_sub(int'(bit_nxt), int'(out_ofs), FRAME_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q   <= '0;
            last_in_q <= 1'b0;
        end else if (strobe.sample) begin
            store_q[wr_pos] <= din;
            last_in_q       <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= 1'b0;
        end else if (strobe.launch) begin
            dout <= bypass ? last_in_q : store_q[rd_pos];
        end
    end

endmodule

// File: rtl/pcm_phase_aligner.sv
`timescale 1ns/1ps
module pcm_phase_aligner
    import pcm_align_pkg::*;
#(
    parameter int FRAME_BITS = DEF_FRAME,
    parameter int LOCK_SYNCS = DEF_LOCK,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_sync,
    input  logic             cfg_sync_high,
    input  logic             cfg_sync_early,
    input  logic [PH_W-1:0]  cfg_phase,
    input  logic [POS_W-1:0] cfg_rx_in_ofs,
    input  logic [POS_W-1:0] cfg_tx_in_ofs,
    input  logic [POS_W-1:0] cfg_tx_out_ofs,
    input  logic             cfg_bypass,
    input  logic             rx_din,
    input  logic             tx_din,
    output logic             rx_dout,
    output logic             tx_dout,
    output logic             locked
);

    logic             sync_evt;
    logic [POS_W-1:0] bit_nxt;
    strobe_t          strobe;

    logic [POS_W-1:0] lane_in_ofs  [LANES];
    logic [POS_W-1:0] lane_out_ofs [LANES];
    logic             lane_din     [LANES];
    logic             lane_dout    [LANES];

    pcm_sync_detect u_sync (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (frm_sync),
        .cfg_high  (cfg_sync_high),
        .cfg_early (cfg_sync_early),
        .evt       (sync_evt)
    );

    pcm_frame_timer #(
        .FRAME_BITS (FRAME_BITS),
        .LOCK_SYNCS (LOCK_SYNCS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .evt       (sync_evt),
        .cfg_phase (cfg_phase),
        .bit_nxt   (bit_nxt),
        .strobe    (strobe),
        .locked    (locked)
    );

    assign lane_in_ofs[LANE_RX]  = cfg_rx_in_ofs;
    assign lane_out_ofs[LANE_RX] = '0;
    assign lane_din[LANE_RX]     = rx_din;
    assign lane_in_ofs[LANE_TX]  = cfg_tx_in_ofs;
    assign lane_out_ofs[LANE_TX] = cfg_tx_out_ofs;
    assign lane_din[LANE_TX]     = tx_din;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pcm_delay_lane #(
            .FRAME_BITS (FRAME_BITS)
        ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .strobe  (strobe),
            .bit_nxt (bit_nxt),
            .in_ofs  (lane_in_ofs[g]),
            .out_ofs (lane_out_ofs[g]),
            .bypass  (cfg_bypass),
            .din     (lane_din[g]),
            .dout    (lane_dout[g])
        );
    end

    assign rx_dout = lane_dout[LANE_RX];
    assign tx_dout = lane_dout[LANE_TX];

endmodule

// File: rtl/pcm_aligner_chk.sv
`timescale 1ns/1ps
module pcm_aligner_chk #(
    parameter int FRAME_BITS = 256,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input logic             clk,
    input logic             rst,
    input logic             sync_evt,
    input logic [1:0]       phase_q,
    input logic [POS_W-1:0] bit_q,
    input logic [1:0]       cfg_phase,
    input logic             locked,
    input logic             rx_dout,
    input logic             tx_dout
);

    // R6
    reload_pos_chk: assert property (@(posedge clk) disable iff (rst)
        sync_evt |=> (phase_q == $past(cfg_phase) && bit_q == '0));

    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        !sync_evt |=> (phase_q == 2'($past(phase_q) + 2'd1)));

    // R1
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_evt && phase_q != 2'd3) |=> $stable(bit_q));

    // R3
    rx_launch_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_dout) |-> (phase_q == 2'd0));

    // R3
    tx_launch_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_dout) |-> (phase_q == 2'd0));

    // R9
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(sync_evt));

    // R10
    lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> (phase_q == cfg_phase && bit_q == '0));

endmodule

bind pcm_phase_aligner pcm_aligner_chk #(
    .FRAME_BITS (FRAME_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync_evt  (sync_evt),
    .phase_q   (u_timer.phase_q),
    .bit_q     (u_timer.bit_q),
    .cfg_phase (cfg_phase),
    .locked    (locked),
    .rx_dout   (rx_dout),
    .tx_dout   (tx_dout)
);

// File: tb/pcm_phase_aligner_test.sv
`timescale 1ns/1ps
module pcm_phase_aligner_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frm_sync = 1'b1;
    logic       cfg_sync_high = 1'b0;
    logic       cfg_sync_early = 1'b0;
    logic [1:0] cfg_phase = 2'd0;
    logic [7:0] cfg_rx_in_ofs = 8'd0;
    logic [7:0] cfg_tx_in_ofs = 8'd0;
    logic [7:0] cfg_tx_out_ofs = 8'd0;
    logic       cfg_bypass = 1'b0;
    logic       rx_din;
    logic       tx_din;
    logic       rx_dout;
    logic       tx_dout;
    logic       locked;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit trk = 1'b0;
    int e_ref = 0;
    int p_ref = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    pcm_phase_aligner uut (
        .clk            (clk),
        .rst            (rst),
        .frm_sync       (frm_sync),
        .cfg_sync_high  (cfg_sync_high),
        .cfg_sync_early (cfg_sync_early),
        .cfg_phase      (cfg_phase),
        .cfg_rx_in_ofs  (cfg_rx_in_ofs),
        .cfg_tx_in_ofs  (cfg_tx_in_ofs),
        .cfg_tx_out_ofs (cfg_tx_out_ofs),
        .cfg_bypass     (cfg_bypass),
        .rx_din         (rx_din),
        .tx_din         (tx_din),
        .rx_dout        (rx_dout),
        .tx_dout        (tx_dout),
        .locked         (locked)
    );

    function automatic logic pat(int t, int salt);
        int h;
        h = t * (t + salt) + 5 * t;
        return (((h >>> 3) ^ (t >>> 1)) & 1) != 0;
    endfunction

    function automatic int dmod(int x);
        int r;
        r = ((x % 256) + 256) % 256;
        return (r == 0) ? 256 : r;
    endfunction

    // Input bits are valid only in phase 1, the phase before capture (R2).
    always @(posedge clk) begin
        int u;
        #2;
        u = cyc - e_ref + p_ref;
        if (trk && u >= 0) begin
            rx_din = ((u % 4) == 1) ? pat(u / 4, 3)  : ~pat(u / 4, 3);
            tx_din = ((u % 4) == 1) ? pat(u / 4, 11) : ~pat(u / 4, 11);
        end else begin
            rx_din = 1'b0;
            tx_din = 1'b0;
        end
    end

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic do_reset(int p, int ri, int si, int so, bit byp, bit high, bit early);
        rst = 1'b1;
        trk = 1'b0;
        cfg_phase = 2'(p);
        cfg_rx_in_ofs = 8'(ri);
        cfg_tx_in_ofs = 8'(si);
        cfg_tx_out_ofs = 8'(so);
        cfg_bypass = byp;
        cfg_sync_high = high;
        cfg_sync_early = early;
        frm_sync = ~high;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (5) @(posedge clk);
        #1;
    endtask

    // Pulse detected on the next active edge; returns at that edge + 5 ns.
    task automatic pulse_now(int p, bit narrow);
        @(posedge clk);
        #1;
        e_ref = cyc + 1;
        p_ref = p;
        trk = 1'b1;
        frm_sync = cfg_sync_high;
        if (narrow) begin
            #4 frm_sync = ~cfg_sync_high;
            @(posedge clk);
            #5;
        end else begin
            @(posedge clk);
            #1 frm_sync = ~cfg_sync_high;
            #4;
        end
    endtask

    task automatic sync_at(int tgt, bit narrow);
        while (cyc < tgt - 1) begin
            @(posedge clk);
            #1;
        end
        frm_sync = cfg_sync_high;
        if (narrow) begin
            #4 frm_sync = ~cfg_sync_high;
            @(posedge clk);
            #5;
        end else begin
            @(posedge clk);
            #1 frm_sync = ~cfg_sync_high;
            #4;
        end
    endtask

    task automatic wait_to(int n);
        while (cyc < n) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        trk = 1'b0;
        repeat (4) @(posedge clk);
        #5;
        // R11
        chk("R11 rx_dout in reset", rx_dout, 1'b0);
        chk("R11 tx_dout in reset", tx_dout, 1'b0);
        chk("R11 locked in reset", locked, 1'b0);
        #1 rst = 1'b0;
        @(posedge clk);
        #5;
        chk("R11 rx_dout after reset", rx_dout, 1'b0);
        chk("R11 locked after reset", locked, 1'b0);
    endtask

    // Streams checked at every phase of every bit (R1 R2 R3 R6 R7 R8).
    task automatic t_stream(string tag, int p, int ri, int si, int so,
                            bit byp, bit high, bit early, bit narrow);
        int drx;
        int dtx;
        do_reset(p, ri, si, so, byp, high, early);
        drx = dmod(0 - ri);
        dtx = dmod(so - si);
        pulse_now(p, narrow);
        for (int k = 0; k < 3200; k++) begin
            int u;
            int tb;
            u = cyc - e_ref + p;
            tb = u / 4;
            if (byp) begin
                if (tb >= 2) begin
                    chk({tag, " R8 rx bypass"}, rx_dout, pat(tb - 1, 3));
                    chk({tag, " R8 tx bypass"}, tx_dout, pat(tb - 1, 11));
                end
            end else begin
                if (tb - drx >= 1)
                    chk({tag, " R7 rx delay"}, rx_dout, pat(tb - drx, 3));
                if (tb - dtx >= 1)
                    chk({tag, " R7 tx delay"}, tx_dout, pat(tb - dtx, 11));
            end
            @(posedge clk);
            #5;
        end
        trk = 1'b0;
    endtask

    task automatic t_lock;
        int e;
        do_reset(0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
        pulse_now(0, 1'b0);
        e = e_ref;
        chk("R9 first sync not locked", locked, 1'b0);
        sync_at(e + 1024, 1'b0);
        chk("R9 one matching sync not locked", locked, 1'b0);
        sync_at(e + 2048, 1'b0);
        chk("R9 two matching syncs locked", locked, 1'b1);
        // R5: narrow pulse missing the active edge is ignored in normal mode
        sync_at(e + 2348, 1'b1);
        chk("R5 narrow pulse ignored", locked, 1'b1);
        wait_to(e + 3071);
        chk("R10 locked before missed sync", locked, 1'b1);
        wait_to(e + 3072);
        chk("R10 missed sync drops lock", locked, 1'b0);
        sync_at(e + 4096, 1'b0);
        chk("R9 relock first", locked, 1'b0);
        sync_at(e + 5120, 1'b0);
        chk("R9 relock second", locked, 1'b1);
        sync_at(e + 5170, 1'b0);
        chk("R10 unexpected sync drops lock", locked, 1'b0);
        // R6: the unexpected sync sets a new frame start
        sync_at(e + 5170 + 1024, 1'b0);
        sync_at(e + 5170 + 2048, 1'b0);
        chk("R6 new grid after resync", locked, 1'b1);
    endtask

    // R5 R4: early capture sees a narrow active-high pulse
    task automatic t_early_lock;
        int e;
        do_reset(1, 0, 0, 0, 1'b0, 1'b1, 1'b1);
        pulse_now(1, 1'b1);
        e = e_ref;
        sync_at(e + 1024, 1'b1);
        sync_at(e + 2048, 1'b1);
        chk("R5 early narrow pulses lock", locked, 1'b1);
        sync_at(e + 2100, 1'b1);
        chk("R5 early narrow pulse seen off grid", locked, 1'b0);
    endtask

    initial begin
        t_reset();
        t_stream("aligned", 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        t_stream("offsets", 3, 5, 3, 10, 1'b0, 1'b0, 1'b0, 1'b0);
        t_stream("bypass", 2, 7, 9, 1, 1'b1, 1'b0, 1'b0, 1'b0);
        t_stream("early_high", 1, 200, 250, 4, 1'b0, 1'b1, 1'b1, 1'b1);
        t_stream("phase2_sync", 2, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        t_lock();
        t_early_lock();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule